// File: doc/BRIEF.md
# Flash Block Protection Arbiter

This block sits beside a flash array of 74 erase blocks and rules on every program or erase request before it reaches the array. It layers four guards. The first is a volatile per-block protection mask, which is enforced only while the active-low guard input is low. The second is a power-down input that refuses everything and clears the volatile state. The third is a global modify-enable input. The fourth is a 64-bit password lock that covers every block except a pair of exempt blocks. The location of that pair depends on whether the parameter blocks sit at the top or the bottom of the address space.

The password is held in write-once storage. Each program step can only clear bits, by ANDing the new data into the stored code, and once every bit is zero the code is fixed. After power-down, the covered blocks are locked again until a key equal to the stored code is presented. Each request receives a registered grant/refuse answer one cycle later. A refusal raises a sticky error bit, which a clear-status command removes.

Top module: `flash_prot_arbiter`

## Requirements
- R1: After reset, a request to a password-covered block is refused until unlocked. The exempt blocks are 12 and 13 when `top_cfg`=0 and 60 and 61 when `top_cfg`=1. Exempt blocks are granted when no other guard applies.
- R2: Command `cmd_op`=0 sets mask bit `cmd_blk` and `cmd_op`=1 clears it. A masked block is refused only while `guard_n` is 0. With `guard_n` at 1 the mask has no effect.
- R3: While `pwrdn_n` is 0, every request is refused without raising the error bit. Power-down also clears the mask, clears the error bit and relocks the password lock.
- R4: While `mod_en` is 0, every request is refused.
- R5: A refused request (with `pwrdn_n` at 1) sets the sticky `st_err` bit. Command `cmd_op`=2 clears it.
- R6: A request to a block index of 74 or above is refused.
- R7: A key equal to the stored code sets `st_unlocked`. A mismatched key leaves the lock state unchanged.
- R8: Command `cmd_op`=3 replaces the code with code AND `cmd_data`, so bits only go from 1 to 0. It acts only while unlocked. While locked it is ignored and sets `st_err`.
- R9: Once the code is all zeros it no longer changes. The code survives power-down, and only `rst_n` restores it to all ones.
- R10: The response (`rsp_valid`, `rsp_grant`, `rsp_erase`) appears one cycle after `req_valid`. The decision is the same for program (`req_erase`=0) and erase (`req_erase`=1).
- R11: Under `rst_n` low, the outputs `rsp_valid`, `rsp_grant`, `st_unlocked` and `st_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| top_cfg | input | 1 | 1: parameter blocks at top, 0: at bottom |
| guard_n | input | 1 | Active-low enable of the per-block mask |
| pwrdn_n | input | 1 | Active-low power-down |
| mod_en | input | 1 | Global program/erase enable |
| req_valid | input | 1 | Request strobe |
| req_blk | input | 7 | Target block index |
| req_erase | input | 1 | 1: erase, 0: program |
| cmd_valid | input | 1 | Register command strobe |
| cmd_op | input | 2 | 0 set mask, 1 clear mask, 2 clear status, 3 program code |
| cmd_blk | input | 7 | Block for mask commands |
| cmd_data | input | 64 | Data for code program |
| key_valid | input | 1 | Unlock attempt strobe |
| key_data | input | 64 | Presented key |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | 1: request may proceed |
| rsp_erase | output | 1 | Operation type of the response |
| st_unlocked | output | 1 | Password lock open |
| st_err | output | 1 | Sticky protection error |

## Verification
The decision logic is first driven with a table that sweeps `top_cfg`, `guard_n`, `mod_en` and the block index in the locked state. This separates the exempt pair of each configuration from the covered blocks, and a masked block from an unmasked one. Directed sequences then cover the following:
- wrong and right keys;
- successive code programs that try to set bits back to 1;
- a program attempt while locked;
- power-down in the middle of use, which must clear the mask and the error bit and relock the lock, while the code is kept.

The final sequence freezes the code at zero and confirms that it still unlocks after power-down.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [1:0] {
    FPA_SET_PROT  = 2'd0,
    FPA_CLR_PROT  = 2'd1,
    FPA_CLR_STAT  = 2'd2,
    FPA_PROG_CODE = 2'd3
  } fpa_cmd_e;

  // 1 when the block lies in the exempt window for the chosen configuration
  function automatic logic fpa_exempt(input int unsigned blk, input logic top,
                                      input int unsigned bot_lo, input int unsigned top_lo,
                                      input int unsigned span);
    int unsigned base;
    base = top ? top_lo : bot_lo;
    return (blk >= base) && (blk < base + span);
  endfunction

  // code after a program step: only 1->0 transitions
  function automatic logic [63:0] fpa_code_next(input logic [63:0] cur, input logic [63:0] data);
    return cur & data;
  endfunction

endpackage

// File: rtl/fpa_prot_reg.sv
module fpa_prot_reg #(
  parameter int NUM_BLOCKS = 74,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwrdn_n,
  input  logic                  set_evt,
  input  logic                  clr_evt,
  input  logic [BLK_W-1:0]      cmd_blk,
  output logic [NUM_BLOCKS-1:0] prot_q
);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
    logic hit;
    assign hit = (cmd_blk == BLK_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                prot_q[i] <= 1'b0;
      else if (!pwrdn_n)         prot_q[i] <= 1'b0;
      else if (set_evt && hit)   prot_q[i] <= 1'b1;
      else if (clr_evt && hit)   prot_q[i] <= 1'b0;
    end
  end

  // R3
  pwrdn_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (prot_q == '0));

endmodule

// File: rtl/fpa_pwlock.sv
module fpa_pwlock #(
  parameter int CODE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn_n,
  input  logic              key_valid,
  input  logic [CODE_W-1:0] key_data,
  input  logic              prog_valid,
  input  logic [CODE_W-1:0] prog_data,
  output logic              unlocked,
  output logic              code_frozen,
  output logic              prog_refused
);
  import fpa_pkg::*;

  logic [CODE_W-1:0] code_q;
  logic              key_match;
  logic              prog_ok;

  assign key_match    = key_valid && (key_data == code_q);
  assign code_frozen  = (code_q == '0);
  assign prog_ok      = prog_valid && pwrdn_n && unlocked && !code_frozen;
  assign prog_refused = prog_valid && pwrdn_n && !unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '1;
    else if (prog_ok) code_q <= CODE_W'(fpa_code_next(64'(code_q), 64'(prog_data)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlocked <= 1'b0;
    else if (!pwrdn_n)  unlocked <= 1'b0;
    else if (key_match) unlocked <= 1'b1;
  end

  // R8
  code_only_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q & ~$past(code_q)) == '0);

  // R9
  frozen_code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_frozen |=> $stable(code_q));

  // R7
  bad_key_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && key_valid && (key_data != code_q)) |=> !unlocked);

  // R3
  pwrdn_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> !unlocked);

endmodule

// File: rtl/fpa_decide.sv
module fpa_decide #(
  parameter int NUM_BLOCKS  = 74,
  parameter int BLK_W       = $clog2(NUM_BLOCKS),
  parameter int EXEMPT_BOT  = 12,
  parameter int EXEMPT_TOP  = 60,
  parameter int EXEMPT_SPAN = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  top_cfg,
  input  logic                  guard_n,
  input  logic                  pwrdn_n,
  input  logic                  mod_en,
  input  logic                  req_valid,
  input  logic [BLK_W-1:0]      req_blk,
  input  logic                  req_erase,
  input  logic [NUM_BLOCKS-1:0] prot_q,
  input  logic                  unlocked,
  output logic                  grant_c,
  output logic                  refuse_evt,
  output logic                  rsp_valid,
  output logic                  rsp_grant,
  output logic                  rsp_erase
);
  import fpa_pkg::*;

  localparam logic [BLK_W:0] NB_W = (BLK_W+1)'(NUM_BLOCKS);

  logic in_range, blk_masked, pw_hit, exempt;

  assign in_range   = ({1'b0, req_blk} < NB_W);
  assign blk_masked = in_range ? prot_q[req_blk] : 1'b0;
  assign exempt     = fpa_exempt(int'(req_blk), top_cfg, EXEMPT_BOT, EXEMPT_TOP, EXEMPT_SPAN);
  assign pw_hit     = !unlocked && !exempt;
  assign grant_c    = req_valid && in_range && pwrdn_n && mod_en
                      && !(!guard_n && blk_masked) && !pw_hit;
  assign refuse_evt = req_valid && pwrdn_n && !grant_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_erase <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= grant_c;
      rsp_erase <= req_valid && req_erase;
    end
  end

  // R3
  pwrdn_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pwrdn_n) |=> (rsp_valid && !rsp_grant));

  // R4
  disable_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mod_en) |=> !rsp_grant);

  // R6
  range_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_range) |=> !rsp_grant);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

endmodule

// File: rtl/fpa_status.sv
module fpa_status (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrdn_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic err_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (!pwrdn_n) err_q <= 1'b0;
    else if (set_evt)  err_q <= 1'b1;
    else if (clr_evt)  err_q <= 1'b0;
  end

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && pwrdn_n && !clr_evt) |=> err_q);

endmodule

// File: rtl/flash_prot_arbiter.sv
module flash_prot_arbiter #(
  parameter int NUM_BLOCKS  = 74,
  parameter int CODE_W      = 64,
  parameter int EXEMPT_BOT  = 12,
  parameter int EXEMPT_TOP  = 60,
  parameter int EXEMPT_SPAN = 2,
  localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              top_cfg,
  input  logic              guard_n,
  input  logic              pwrdn_n,
  input  logic              mod_en,
  input  logic              req_valid,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic              req_erase,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [CODE_W-1:0] cmd_data,
  input  logic              key_valid,
  input  logic [CODE_W-1:0] key_data,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_erase,
  output logic              st_unlocked,
  output logic              st_err
);
  import fpa_pkg::*;

  logic [NUM_BLOCKS-1:0] prot_q;
  logic set_prot, clr_prot, clr_stat, prog_code;
  logic grant_c, refuse_evt, prog_refused, code_frozen;

  assign set_prot  = cmd_valid && (fpa_cmd_e'(cmd_op) == FPA_SET_PROT);
  assign clr_prot  = cmd_valid && (fpa_cmd_e'(cmd_op) == FPA_CLR_PROT);
  assign clr_stat  = cmd_valid && (fpa_cmd_e'(cmd_op) == FPA_CLR_STAT);
  assign prog_code = cmd_valid && (fpa_cmd_e'(cmd_op) == FPA_PROG_CODE);

  fpa_prot_reg #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_prot (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .set_evt(set_prot), .clr_evt(clr_prot), .cmd_blk(cmd_blk), .prot_q(prot_q)
  );

  fpa_pwlock #(.CODE_W(CODE_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .key_valid(key_valid), .key_data(key_data),
    .prog_valid(prog_code), .prog_data(cmd_data),
    .unlocked(st_unlocked), .code_frozen(code_frozen), .prog_refused(prog_refused)
  );

  fpa_decide #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .EXEMPT_BOT(EXEMPT_BOT),
               .EXEMPT_TOP(EXEMPT_TOP), .EXEMPT_SPAN(EXEMPT_SPAN)) u_dec (
    .clk(clk), .rst_n(rst_n), .top_cfg(top_cfg), .guard_n(guard_n),
    .pwrdn_n(pwrdn_n), .mod_en(mod_en), .req_valid(req_valid),
    .req_blk(req_blk), .req_erase(req_erase), .prot_q(prot_q),
    .unlocked(st_unlocked), .grant_c(grant_c), .refuse_evt(refuse_evt),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_erase(rsp_erase)
  );

  fpa_status u_stat (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .set_evt(refuse_evt || prog_refused), .clr_evt(clr_stat), .err_q(st_err)
  );

  // R5
  refuse_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse_evt && pwrdn_n) |=> st_err);

  // R1
  locked_grant_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_c && !st_unlocked) |-> (int'(req_blk) >= (top_cfg ? EXEMPT_TOP : EXEMPT_BOT)));

  // R2
  masked_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !guard_n && (int'(req_blk) < NUM_BLOCKS) && prot_q[req_blk]) |-> !grant_c);

endmodule

// File: tb/flash_prot_arbiter_tb.sv
module flash_prot_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic top_cfg = 1'b0, guard_n = 1'b1, pwrdn_n = 1'b1, mod_en = 1'b1;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [6:0] req_blk = '0, cmd_blk = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [63:0] cmd_data = '0, key_data = '0;
  logic key_valid = 1'b0;
  logic rsp_valid, rsp_grant, rsp_erase, st_unlocked, st_err;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [63:0] exp_code;

  always #5 clk = ~clk;

  flash_prot_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .top_cfg(top_cfg), .guard_n(guard_n),
    .pwrdn_n(pwrdn_n), .mod_en(mod_en), .req_valid(req_valid),
    .req_blk(req_blk), .req_erase(req_erase), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_data(cmd_data),
    .key_valid(key_valid), .key_data(key_data), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_erase(rsp_erase), .st_unlocked(st_unlocked),
    .st_err(st_err)
  );

  // {top_cfg, guard_n, mod_en, blk[6:0], expected grant}, lock closed, mask on 13 and 61
  localparam logic [10:0] VEC [12] = '{
    {1'b0, 1'b1, 1'b1, 7'd12, 1'b1},
    {1'b0, 1'b1, 1'b1, 7'd13, 1'b1},
    {1'b0, 1'b0, 1'b1, 7'd13, 1'b0},
    {1'b0, 1'b0, 1'b1, 7'd12, 1'b1},
    {1'b0, 1'b1, 1'b1, 7'd0,  1'b0},
    {1'b0, 1'b1, 1'b1, 7'd60, 1'b0},
    {1'b1, 1'b1, 1'b1, 7'd60, 1'b1},
    {1'b1, 1'b0, 1'b1, 7'd61, 1'b0},
    {1'b1, 1'b1, 1'b1, 7'd61, 1'b1},
    {1'b1, 1'b1, 1'b1, 7'd12, 1'b0},
    {1'b0, 1'b1, 1'b0, 7'd12, 1'b0},
    {1'b1, 1'b1, 1'b0, 7'd60, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [6:0] blk, input logic erase);
    @(negedge clk);
    req_valid = 1'b1; req_blk = blk; req_erase = erase;
    @(negedge clk);
    req_valid = 1'b0; req_erase = 1'b0;
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [6:0] blk, input logic [63:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = blk; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_key(input logic [63:0] k);
    @(negedge clk);
    key_valid = 1'b1; key_data = k;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic pwrdn_pulse();
    @(negedge clk); pwrdn_n = 1'b0;
    @(negedge clk); pwrdn_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_code = '1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rsp_valid", rsp_valid, 1'b0);
    check("R11 rsp_grant", rsp_grant, 1'b0);
    check("R11 st_unlocked", st_unlocked, 1'b0);
    check("R11 st_err", st_err, 1'b0);
    rst_n = 1'b1;

    do_cmd(2'd0, 7'd13, '0);
    do_cmd(2'd0, 7'd61, '0);
    for (int i = 0; i < 12; i++) begin
      top_cfg = VEC[i][10]; guard_n = VEC[i][9]; mod_en = VEC[i][8];
      do_req(VEC[i][7:1], i[0]);
      check($sformatf("R1/R2/R4 vec%0d grant", i), rsp_grant, VEC[i][0]);
      check("R10 rsp_valid", rsp_valid, 1'b1);
    end
    top_cfg = 1'b0; guard_n = 1'b1; mod_en = 1'b1;
    check("R5 err set by refusal", st_err, 1'b1);
    do_cmd(2'd2, '0, '0);
    check("R5 clear status", st_err, 1'b0);

    do_key(64'h0);
    check("R7 bad key keeps lock", st_unlocked, 1'b0);
    do_key('1);
    check("R7 good key unlocks", st_unlocked, 1'b1);
    do_req(7'd0, 1'b0);
    check("R1 unlocked block 0", rsp_grant, 1'b1);

    guard_n = 1'b0;
    do_req(7'd13, 1'b0);
    check("R2 masked refused", rsp_grant, 1'b0);
    check("R5 err after mask refusal", st_err, 1'b1);
    do_cmd(2'd1, 7'd13, '0);
    do_req(7'd13, 1'b0);
    check("R2 mask cleared", rsp_grant, 1'b1);
    guard_n = 1'b1;
    do_cmd(2'd2, '0, '0);

    do_req(7'd73, 1'b0);
    check("R6 last block granted", rsp_grant, 1'b1);
    do_req(7'd74, 1'b0);
    check("R6 block 74 refused", rsp_grant, 1'b0);
    do_req(7'd127, 1'b1);
    check("R6 block 127 refused", rsp_grant, 1'b0);
    do_req(7'd5, 1'b1);
    check("R10 erase granted", rsp_grant, 1'b1);
    check("R10 erase echoed", rsp_erase, 1'b1);

    do_cmd(2'd3, '0, 64'hFFFF_0000_FFFF_FF00);
    exp_code = exp_code & 64'hFFFF_0000_FFFF_FF00;
    do_cmd(2'd3, '0, 64'h0F0F_FFFF_FFFF_FFFF);
    exp_code = exp_code & 64'h0F0F_FFFF_FFFF_FFFF;
    do_cmd(2'd0, 7'd20, '0);
    do_cmd(2'd2, '0, '0);

    // power-down: refuse without error, relock, clear mask
    @(negedge clk); pwrdn_n = 1'b0;
    req_valid = 1'b1; req_blk = 7'd12;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 refused in power-down", rsp_grant, 1'b0);
    check("R3 no error in power-down", st_err, 1'b0);
    check("R3 relocked", st_unlocked, 1'b0);
    pwrdn_n = 1'b1;

    do_cmd(2'd3, '0, 64'h0);
    check("R8 program while locked errors", st_err, 1'b1);
    do_key('1);
    check("R8 old code no longer matches", st_unlocked, 1'b0);
    do_key(exp_code);
    check("R8 programmed code unlocks", st_unlocked, 1'b1);
    guard_n = 1'b0;
    do_req(7'd20, 1'b0);
    check("R3 mask cleared by power-down", rsp_grant, 1'b1);
    guard_n = 1'b1;

    do_cmd(2'd3, '0, 64'h0);
    exp_code = '0;
    do_cmd(2'd3, '0, '1);
    pwrdn_pulse();
    do_key(64'h1);
    check("R9 frozen code rejects other key", st_unlocked, 1'b0);
    do_key(64'h0);
    check("R9 frozen zero code unlocks", st_unlocked, 1'b1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule